// File: doc/BRIEF.md
# Multi-Mode 8x8 Multiplier Unit

This block is the multiply engine of a small processor datapath. It takes two 8-bit operands and a 3-bit mode code and returns a 16-bit product. The mode selects how the operands are read: both unsigned, both two's complement, or the first signed and the second unsigned. Each of these readings has a fractional variant, which returns the product shifted left by one bit. The product always goes to one fixed destination pair, whatever registers supplied the operands. For that reason the outputs are simply a high byte and a low byte.

The unit updates only two flags: zero and carry. Operand fetch, writeback into the register file and the flag register itself belong to the surrounding pipeline. A request is made by raising `start` while `busy` is low. The operands and the mode are captured on that clock edge. On the next edge the result is registered and `done` pulses for one cycle. The result outputs then hold until the next completion.

Top module: `mulx8_core`

## Requirements
- R1: While reset is asserted, and after it is released until the first completion, `busy`, `done`, `prod_hi`, `prod_lo`, `flag_z` and `flag_c` are all 0. Reset is asynchronous on assertion.
- R2: When `start` is high at a rising edge while `busy` is low, the unit captures `opnd_a`, `opnd_b` and `mode` at that edge (edge 1). `busy` is high until edge 2. At edge 2 the result is registered and `done` goes high for exactly one cycle. Operand changes after edge 1 do not affect the result.
- R3: When `start` is high at an edge where `busy` is high, it is ignored. The result in flight is not altered, and no extra operation or extra `done` pulse follows.
- R4: When `mode[1:0]` is 00 (and also for the unused code 11), both operands are unsigned.
- R5: When `mode[1:0]` is 01, both operands are two's complement.
- R6: When `mode[1:0]` is 10, `opnd_a` is two's complement and `opnd_b` is unsigned.
- R7: When `mode[2]` is 1 (fractional), the result is the 16-bit product shifted left by one bit, with bit 0 cleared and the old bit 15 dropped. When `mode[2]` is 0, the result is the product itself. `prod_hi` carries result bits 15..8 and `prod_lo` carries bits 7..0.
- R8: `flag_c` equals bit 15 of the product before the fractional shift.
- R9: `flag_z` is 1 exactly when the final 16-bit result (after any shift) is zero.
- R10: The result and flag outputs hold their values between completions. A `start` in the cycle where `done` is high is accepted, so operations may issue every two cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset, asynchronous assertion, synchronised release |
| start | input | 1 | Request a multiply; accepted when `busy` is low |
| mode | input | 3 | Bit 2 is fractional; bits 1:0 are 00 uu, 01 ss, 10 su, 11 uu |
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand |
| busy | output | 1 | High in the cycle between acceptance and completion |
| done | output | 1 | One-cycle pulse when the result is valid |
| prod_hi | output | 8 | Result bits 15..8 |
| prod_lo | output | 8 | Result bits 7..0 |
| flag_z | output | 1 | Final result is zero |
| flag_c | output | 1 | Bit 15 of the unshifted product |

## Verification
The bench goes after operand pairs where the modes disagree. One example is 0x05 by 0xFD, which gives 0x04F1 unsigned and 0xFFF1 signed; swapping the operands in signed-by-unsigned mode tells the two operand roles apart. A unit that extends the wrong operand, or treats code 11 as signed, returns the other value. Fractional cases are chosen so that bit 15 before the shift differs from bit 15 after it (0xC0 by 0x80 and 0xFF by 0x81). A unit that takes carry after the shift therefore shows the wrong `flag_c`. The bench also changes operands while `busy` is high, raises `start` mid-operation, issues back-to-back requests in the `done` cycle and resets mid-operation. A unit that does not latch its operands, accepts requests while busy, drops back-to-back requests or loses its reset state gives a wrong product or a wrong pulse count.

// File: rtl/mulx8_pkg.sv
package mulx8_pkg;

  typedef enum logic [1:0] {
    KIND_UU  = 2'b00,
    KIND_SS  = 2'b01,
    KIND_SU  = 2'b10,
    KIND_RSV = 2'b11
  } kind_e;

  typedef struct packed {
    logic  frac;
    kind_e kind;
  } mode_t;

endpackage

// File: rtl/mulx8_rst_sync.sv
module mulx8_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/mulx8_opnd.sv
module mulx8_opnd
  import mulx8_pkg::*;
#(
  parameter int unsigned W  = 8,
  localparam int unsigned PW = 2 * W
) (
  input  kind_e          kind,
  input  logic [W-1:0]   a_in,
  input  logic [W-1:0]   b_in,
  output logic [PW-1:0]  a_ext,
  output logic [W:0]     b_ext
);

  logic a_sgn;
  logic b_sgn;

  always_comb begin
    unique case (kind)
      KIND_SS: begin a_sgn = 1'b1; b_sgn = 1'b1; end
      KIND_SU: begin a_sgn = 1'b1; b_sgn = 1'b0; end
      default: begin a_sgn = 1'b0; b_sgn = 1'b0; end
    endcase
  end

  always_comb begin
    a_ext = {{W{a_sgn & a_in[W-1]}}, a_in};
    b_ext = {b_sgn & b_in[W-1], b_in};
  end

endmodule

// File: rtl/mulx8_array.sv
module mulx8_array #(
  parameter int unsigned W  = 8,
  localparam int unsigned PW = 2 * W
) (
  input  logic [PW-1:0] a_ext,
  input  logic [W:0]    b_ext,
  output logic [PW-1:0] prod
);

  logic [PW-1:0] rows [W];
  logic [PW-1:0] top_row;
  logic [PW-1:0] acc;

  for (genvar gi = 0; gi < W; gi++) begin : g_row
    assign rows[gi] = b_ext[gi] ? (a_ext << gi) : '0;
  end

  // The extra operand bit carries negative weight.
  assign top_row = b_ext[W] ? (a_ext << W) : '0;

  always_comb begin
    acc = '0;
    for (int i = 0; i < W; i++) begin
      acc = acc + rows[i];
    end
    acc = acc - top_row;
  end

  assign prod = acc;

endmodule

// File: rtl/mulx8_post.sv
module mulx8_post #(
  parameter int unsigned W  = 8,
  localparam int unsigned PW = 2 * W
) (
  input  logic [PW-1:0] prod,
  input  logic          frac,
  output logic [PW-1:0] result,
  output logic          z,
  output logic          c
);

  always_comb begin
    c      = prod[PW-1];
    result = frac ? {prod[PW-2:0], 1'b0} : prod;
    z      = (result == '0);
  end

endmodule

// File: rtl/mulx8_ctrl.sv
module mulx8_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic busy,
  output logic done
);

  logic busy_q, busy_d;
  logic done_q, done_d;

  always_comb begin
    accept = start & ~busy_q;
    busy_d = accept;
    done_d = busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;

endmodule

// File: rtl/mulx8_core.sv
module mulx8_core
  import mulx8_pkg::*;
#(
  parameter int unsigned W  = 8,
  localparam int unsigned PW = 2 * W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [2:0]   mode,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] prod_hi,
  output logic [W-1:0] prod_lo,
  output logic         flag_z,
  output logic         flag_c
);

  logic rst_n_i;
  logic accept;

  mulx8_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  mulx8_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .start  (start),
    .accept (accept),
    .busy   (busy),
    .done   (done)
  );

  // Operand capture stage
  logic [W-1:0] a_q, a_d;
  logic [W-1:0] b_q, b_d;
  mode_t        m_q, m_d;

  always_comb begin
    a_d = a_q;
    b_d = b_q;
    m_d = m_q;
    if (accept) begin
      a_d = opnd_a;
      b_d = opnd_b;
      m_d = mode_t'(mode);
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      a_q <= '0;
      b_q <= '0;
      m_q <= '0;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
      m_q <= m_d;
    end
  end

  // Datapath
  logic [PW-1:0] a_ext;
  logic [W:0]    b_ext;
  logic [PW-1:0] raw_prod;
  logic [PW-1:0] fin_res;
  logic          fin_z, fin_c;

  mulx8_opnd #(.W(W)) u_opnd (
    .kind  (m_q.kind),
    .a_in  (a_q),
    .b_in  (b_q),
    .a_ext (a_ext),
    .b_ext (b_ext)
  );

  mulx8_array #(.W(W)) u_arr (
    .a_ext (a_ext),
    .b_ext (b_ext),
    .prod  (raw_prod)
  );

  mulx8_post #(.W(W)) u_post (
    .prod   (raw_prod),
    .frac   (m_q.frac),
    .result (fin_res),
    .z      (fin_z),
    .c      (fin_c)
  );

  // Result stage, loaded in the busy cycle
  logic [PW-1:0] res_q, res_d;
  logic          z_q, z_d;
  logic          c_q, c_d;

  always_comb begin
    res_d = res_q;
    z_d   = z_q;
    c_d   = c_q;
    if (busy) begin
      res_d = fin_res;
      z_d   = fin_z;
      c_d   = fin_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      res_q <= '0;
      z_q   <= 1'b0;
      c_q   <= 1'b0;
    end else begin
      res_q <= res_d;
      z_q   <= z_d;
      c_q   <= c_d;
    end
  end

  assign prod_hi = res_q[PW-1:W];
  assign prod_lo = res_q[W-1:0];
  assign flag_z  = z_q;
  assign flag_c  = c_q;

endmodule

// File: rtl/mulx8_chk.sv
module mulx8_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [2:0] mode,
  input logic       busy,
  input logic       done,
  input logic [7:0] prod_hi,
  input logic [7:0] prod_lo,
  input logic       flag_z,
  input logic       flag_c
);

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_busy_to_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (done && !busy));

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_no_extra_op_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start && !busy, 2));

  p_frac_lsb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(mode[2], 2)) |-> (prod_lo[0] == 1'b0));

  p_carry_int_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(mode[2], 2)) |-> (flag_c == prod_hi[7]));

  p_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_z |-> ({prod_hi, prod_lo} == 16'h0000));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({prod_hi, prod_lo, flag_z, flag_c}));

endmodule

bind mulx8_core mulx8_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .mode    (mode),
  .busy    (busy),
  .done    (done),
  .prod_hi (prod_hi),
  .prod_lo (prod_lo),
  .flag_z  (flag_z),
  .flag_c  (flag_c)
);

// File: tb/sim_mulx8_core.sv
module sim_mulx8_core;

  logic       clk;
  logic       rst_n;
  logic       start;
  logic [2:0] mode;
  logic [7:0] opnd_a, opnd_b;
  logic       busy, done;
  logic [7:0] prod_hi, prod_lo;
  logic       flag_z, flag_c;

  int n_chk  = 0;
  int n_fail = 0;

  mulx8_core u0 (
    .clk (clk), .rst_n (rst_n), .start (start), .mode (mode),
    .opnd_a (opnd_a), .opnd_b (opnd_b), .busy (busy), .done (done),
    .prod_hi (prod_hi), .prod_lo (prod_lo), .flag_z (flag_z), .flag_c (flag_c)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {mode, a, b, expected result, z, c}
  localparam int NV = 16;
  localparam logic [36:0] VEC [NV] = '{
    {3'b000, 8'h00, 8'h37, 16'h0000, 1'b1, 1'b0},  // R4 R9
    {3'b000, 8'hFF, 8'hFF, 16'hFE01, 1'b0, 1'b1},  // R4 R8
    {3'b000, 8'h05, 8'hFD, 16'h04F1, 1'b0, 1'b0},  // R4
    {3'b011, 8'h05, 8'hFD, 16'h04F1, 1'b0, 1'b0},  // R4 code 11
    {3'b001, 8'hFF, 8'hFF, 16'h0001, 1'b0, 1'b0},  // R5
    {3'b001, 8'h80, 8'h7F, 16'hC080, 1'b0, 1'b1},  // R5
    {3'b001, 8'h05, 8'hFD, 16'hFFF1, 1'b0, 1'b1},  // R5
    {3'b010, 8'hFF, 8'hFF, 16'hFF01, 1'b0, 1'b1},  // R6
    {3'b010, 8'h7F, 8'hFF, 16'h7E81, 1'b0, 1'b0},  // R6
    {3'b010, 8'h05, 8'hFD, 16'h04F1, 1'b0, 1'b0},  // R6 b unsigned
    {3'b010, 8'hFD, 8'h05, 16'hFFF1, 1'b0, 1'b1},  // R6 a signed
    {3'b100, 8'hC0, 8'h80, 16'hC000, 1'b0, 1'b0},  // R7 R8
    {3'b100, 8'hFF, 8'h81, 16'h00FE, 1'b0, 1'b1},  // R7 R8
    {3'b101, 8'h80, 8'h80, 16'h8000, 1'b0, 1'b0},  // R7
    {3'b110, 8'h80, 8'hFF, 16'h0100, 1'b0, 1'b1},  // R7 R6
    {3'b101, 8'h00, 8'h80, 16'h0000, 1'b1, 1'b0}   // R7 R9
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] m, input logic [7:0] a, input logic [7:0] b);
    start  = 1'b1;
    mode   = m;
    opnd_a = a;
    opnd_b = b;
  endtask

  task automatic check_result(input string tag, input logic [15:0] r, input logic z, input logic c);
    chk({tag, " product"}, {16'h0, prod_hi, prod_lo}, {16'h0, r});
    chk({tag, " R9 zero"}, {31'h0, flag_z}, {31'h0, z});
    chk({tag, " R8 carry"}, {31'h0, flag_c}, {31'h0, c});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; mode = 3'b0; opnd_a = 8'h0; opnd_b = 8'h0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", {31'h0, busy}, 32'h0);
    chk("R1 done in reset", {31'h0, done}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_result("R1 after reset", 16'h0000, 1'b0, 1'b0);
    chk("R1 busy idle", {31'h0, busy}, 32'h0);

    // Table walk: R2 timing, R4..R9 values
    for (int i = 0; i < NV; i++) begin
      logic [36:0] v;
      v = VEC[i];
      issue(v[36:34], v[33:26], v[25:18]);
      @(negedge clk);
      start  = 1'b0;
      opnd_a = ~v[33:26];
      opnd_b = 8'h5A;
      mode   = ~v[36:34];
      chk("R2 busy after accept", {31'h0, busy}, 32'h1);
      chk("R2 no early done", {31'h0, done}, 32'h0);
      @(negedge clk);
      chk("R2 done pulse", {31'h0, done}, 32'h1);
      chk("R2 busy cleared", {31'h0, busy}, 32'h0);
      check_result($sformatf("vec%0d R4-7", i), v[17:2], v[1], v[0]);
      @(negedge clk);
      chk("R2 done one cycle", {31'h0, done}, 32'h0);
      check_result("R10 hold", v[17:2], v[1], v[0]);
    end

    // R3: start while busy is ignored
    issue(3'b000, 8'h10, 8'h10);
    @(negedge clk);
    issue(3'b001, 8'hFF, 8'h02);
    @(negedge clk);
    start = 1'b0;
    chk("R3 done", {31'h0, done}, 32'h1);
    check_result("R3 result untouched", 16'h0100, 1'b0, 1'b0);
    @(negedge clk);
    chk("R3 no second op busy", {31'h0, busy}, 32'h0);
    @(negedge clk);
    chk("R3 no second done", {31'h0, done}, 32'h0);
    check_result("R3 R10 held", 16'h0100, 1'b0, 1'b0);

    // R10: back-to-back issue in the done cycle
    issue(3'b000, 8'h03, 8'h04);
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk("R10 first done", {31'h0, done}, 32'h1);
    check_result("R10 first", 16'h000C, 1'b0, 1'b0);
    issue(3'b001, 8'hFE, 8'h03);
    @(negedge clk);
    start = 1'b0;
    chk("R10 second accepted", {31'h0, busy}, 32'h1);
    @(negedge clk);
    chk("R10 second done", {31'h0, done}, 32'h1);
    check_result("R10 second", 16'hFFFA, 1'b0, 1'b1);

    // R1: reset in the middle of an operation
    @(negedge clk);
    issue(3'b000, 8'hFF, 8'hFF);
    @(negedge clk);
    start = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R1 mid-op busy", {31'h0, busy}, 32'h0);
    chk("R1 mid-op done", {31'h0, done}, 32'h0);
    check_result("R1 mid-op", 16'h0000, 1'b0, 1'b0);
    @(negedge clk);
    chk("R1 no done in reset", {31'h0, done}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after reset", {31'h0, done | busy}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule